// File: doc/BRIEF.md
# Interprocessor Parallel Word Link

This block joins two processors with a 16-bit word path built from a pair of I/O channel cards. Card 0 is the sending card and card 1 is the receiving card. Each card exposes a host-side I/O command port. Through that port the host can write the output buffer, read or OR-merge the input buffer, set or clear control, set the flag, test the flag with a skip, and apply a control-reset. Any of these commands can carry a modifier that clears the flag. Each card keeps control, command, flag, flag-buffer and service-request flip-flops. The card raises an interrupt request when control, flag and flag-buffer are all set.

A set-control command on the sending card starts a word transfer. The word leaves on a byte-wide valid/ready link with the high byte first. On the receive side, the first byte of a pair waits in a holdover register. When the second byte arrives, the word is formed and written to the receiving card's input buffer. That card then raises its flag and drops its command bit.

For self-test, a loopback mode bypasses the byte link. In this mode a set-control on either card copies its output buffer directly into the other card's input buffer and sets the other card's flag.

Top module: `xlink_top`

## Requirements
- R1: After synchronous active-low reset, each card has control and command clear, flag and service request set, and no interrupt request. A load of either input buffer returns 0, and the transmitter is idle (`tx_valid` low).
- R2: An output command (op code 1) only stores `host_wdata` in the card's output buffer. No byte is transmitted and the flag is unchanged.
- R3: Set-control (op 4) sets both control and command on the next cycle. Clear-control (op 5) clears both.
- R4: Control-reset (op 9) clears control and command and leaves the flag as it was.
- R5: In link mode, set-control on card 0 with the transmitter idle sends the output buffer as two bytes on `tx_byte`, bits 15:8 first and bits 7:0 second. Each byte stays valid and unchanged until a cycle in which `tx_ready` is high.
- R6: A set-control on card 0 while both bytes of the previous word have not yet been sent starts no new transfer. It still sets control and command.
- R7: A received byte with no byte held is kept in the holdover register, and the flag is not changed. The next received byte forms the word {held, new}. On the following cycle that word is in card 1's input buffer, card 1's flag is set and card 1's command bit is clear.
- R8: Load-input (op 2) returns the input buffer on `host_rdata` in the same cycle. Merge-input (op 3) returns `host_wdata` OR the input buffer.
- R9: Skip-if-clear (op 7) asserts `host_skip` in that cycle when the flag is 0. Skip-if-set (op 8) asserts it when the flag is 1. Otherwise `host_skip` is 0.
- R10: Set-flag (op 6) sets the flag. A command with `host_hc` high leaves the flag clear on the next cycle, unless a word lands on that card in the same cycle, in which case the flag ends up set.
- R11: With `diag_mode` high, set-control on one card copies its output buffer into the other card's input buffer and sets the other card's flag, with nothing sent on `tx_byte`. In this mode `rx_ready` is low and bytes offered on `rx_byte` are ignored and not held.
- R12: `srq` always equals the card's flag. `irq` is high exactly when control, flag and flag-buffer are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diag_mode | input | 1 | 1 = loopback between the cards, 0 = byte link |
| host_op | input | 2x4 | Command op code per card (0 none) |
| host_hc | input | 2 | Flag-clear modifier per card |
| host_wdata | input | 2x16 | Host data per card |
| host_rdata | output | 2x16 | Load/merge result per card |
| host_skip | output | 2 | Skip indication per card |
| flag | output | 2 | Flag bit per card |
| srq | output | 2 | Service request per card |
| irq | output | 2 | Interrupt request per card |
| ctl | output | 2 | Control bit per card |
| cmd | output | 2 | Command bit per card |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link accepts outgoing byte |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts incoming byte |
| rx_byte | input | 8 | Incoming byte |

## Verification
The embedded assertions check the following on every cycle: service-request tracking of the flag, control and command after set-control and control-reset, flag retention across control-reset, flag clearing by the modifier, arrival of a word into the input buffer, holdover entry on a lone byte, and a stalled outgoing byte staying put. The directed scenarios are the only checks for end-to-end properties. These are the high-then-low byte order on the link, that a set-control is dropped while the transmitter is busy, the load and merge read values, skip polarity, the race between a flag clear and an arrival, and the loopback copy. They also cover a byte offered during loopback leaving no stale holdover behind.

// File: rtl/xlink_pkg.sv
// Shared types for the interprocessor word link.
// Assumes: op codes are fixed by the host command decoder.
package xlink_pkg;
    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_OUT   = 4'd1,
        OP_LOAD  = 4'd2,
        OP_MERGE = 4'd3,
        OP_SETC  = 4'd4,
        OP_CLRC  = 4'd5,
        OP_SETF  = 4'd6,
        OP_SKPC  = 4'd7,
        OP_SKPS  = 4'd8,
        OP_CRS   = 4'd9
    } xl_op_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HI   = 2'd1,
        TX_LO   = 2'd2
    } xl_tx_e;
endpackage

// File: rtl/xlink_card.sv
// One I/O channel card: host command decode, buffers and the
// control/command/flag/flag-buffer/service-request flip-flops.
// Assumes: at most one host op per cycle; in_load marks a complete word
// arriving from the link or from the partner card in loopback.
module xlink_card
    import xlink_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  xl_op_e       op,
    input  logic         hc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         skip,
    input  logic         in_load,
    input  logic         in_clr_cmd,
    input  logic [W-1:0] in_word,
    output logic         stc_o,
    output logic [W-1:0] obuf_o,
    output logic         flag_o,
    output logic         srq_o,
    output logic         irq_o,
    output logic         ctl_o,
    output logic         cmd_o
);
    logic         ctl_q, cmd_q, flg_q, fbf_q, srq_q;
    logic [W-1:0] ibuf_q, obuf_q;

    // Card state update: host op first, then flag-clear modifier, then arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= 1'b0;
            cmd_q  <= 1'b0;
            flg_q  <= 1'b1;
            fbf_q  <= 1'b1;
            srq_q  <= 1'b1;
            ibuf_q <= '0;
            obuf_q <= '0;
        end else begin
            case (op)
                OP_OUT:  obuf_q <= wdata;
                OP_SETC: begin ctl_q <= 1'b1; cmd_q <= 1'b1; end
                OP_CLRC, OP_CRS: begin ctl_q <= 1'b0; cmd_q <= 1'b0; end
                OP_SETF: begin flg_q <= 1'b1; fbf_q <= 1'b1; srq_q <= 1'b1; end
                default: ;
            endcase
            if (hc) begin
                flg_q <= 1'b0;
                fbf_q <= 1'b0;
                srq_q <= 1'b0;
            end
            if (in_load) begin
                ibuf_q <= in_word;
                flg_q  <= 1'b1;
                fbf_q  <= 1'b1;
                srq_q  <= 1'b1;
                if (in_clr_cmd) cmd_q <= 1'b0;
            end
        end
    end

    // Host read path and skip test, valid in the cycle of the op.
    always_comb begin
        rdata = '0;
        if (op == OP_LOAD)  rdata = ibuf_q;
        if (op == OP_MERGE) rdata = wdata | ibuf_q;
        skip = ((op == OP_SKPC) && !flg_q) || ((op == OP_SKPS) && flg_q);
    end

    assign stc_o  = (op == OP_SETC);
    assign obuf_o = obuf_q;
    assign flag_o = flg_q;
    assign srq_o  = srq_q;
    assign ctl_o  = ctl_q;
    assign cmd_o  = cmd_q;
    assign irq_o  = ctl_q && flg_q && fbf_q;

    AST_SRQ_TRACKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        srq_q == flg_q); // R12
    AST_SETC_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SETC && !in_load) |=> (ctl_q && cmd_q)); // R3
    AST_CRS_DROPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CRS) |=> (!ctl_q && !cmd_q)); // R4
    AST_CRS_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CRS && !hc && !in_load) |=> (flg_q == $past(flg_q))); // R4
    AST_HC_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hc && !in_load) |=> !flg_q); // R10
    AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        in_load |=> (flg_q && ibuf_q == $past(in_word))); // R7
endmodule

// File: rtl/xlink_tx_ser.sv
// Transmit sequencer: sends a word as two bytes, high byte first,
// over a valid/ready link. Assumes start pulses are dropped while busy.
module xlink_tx_ser
    import xlink_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   word,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic [W/2-1:0] tx_byte
);
    localparam int B = W / 2;

    xl_tx_e       st_q;
    logic [W-1:0] word_q;

    // Byte sequencing: idle -> high byte -> low byte -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            word_q <= '0;
        end else begin
            case (st_q)
                TX_IDLE: if (start) begin
                    word_q <= word;
                    st_q   <= TX_HI;
                end
                TX_HI:   if (tx_ready) st_q <= TX_LO;
                TX_LO:   if (tx_ready) st_q <= TX_IDLE;
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign tx_valid = (st_q != TX_IDLE);
    assign tx_byte  = (st_q == TX_HI) ? word_q[W-1 -: B] : word_q[B-1:0];

    AST_TX_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R5
endmodule

// File: rtl/xlink_rx_asm.sv
// Receive assembler: pairs incoming bytes into a word through a
// holdover register. Assumes accept low means the link is bypassed.
module xlink_rx_asm #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           rx_valid,
    output logic           rx_ready,
    input  logic [W/2-1:0] rx_byte,
    output logic           word_valid,
    output logic [W-1:0]   word
);
    localparam int B = W / 2;

    logic         holding_q;
    logic [B-1:0] hold_q;
    logic         fire;

    assign rx_ready = accept;
    assign fire     = rx_valid && accept;

    // Holdover: first byte parks here, second byte completes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holding_q <= 1'b0;
            hold_q    <= '0;
        end else if (fire) begin
            if (holding_q) begin
                holding_q <= 1'b0;
            end else begin
                hold_q    <= rx_byte;
                holding_q <= 1'b1;
            end
        end
    end

    assign word_valid = fire && holding_q;
    assign word       = {hold_q, rx_byte};

    AST_RX_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !holding_q) |=> holding_q); // R7
    AST_RX_PAIR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !holding_q); // R7
endmodule

// File: rtl/xlink_top.sv
// Interprocessor word link: card 0 sends, card 1 receives; loopback
// mode joins the two cards without the byte link.
// Assumes: the far processor's link is attached to tx_* and rx_*.
module xlink_top
    import xlink_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                diag_mode,
    input  logic [1:0][3:0]     host_op,
    input  logic [1:0]          host_hc,
    input  logic [1:0][W-1:0]   host_wdata,
    output logic [1:0][W-1:0]   host_rdata,
    output logic [1:0]          host_skip,
    output logic [1:0]          flag,
    output logic [1:0]          srq,
    output logic [1:0]          irq,
    output logic [1:0]          ctl,
    output logic [1:0]          cmd,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [W/2-1:0]      tx_byte,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [W/2-1:0]      rx_byte
);
    localparam int NCARD = 2;

    logic [NCARD-1:0]        stc;
    logic [NCARD-1:0][W-1:0] obuf;
    logic [NCARD-1:0]        ld;
    logic [NCARD-1:0]        ld_clr_cmd;
    logic [NCARD-1:0][W-1:0] ld_word;
    logic                    asm_valid;
    logic [W-1:0]            asm_word;

    generate
        for (genvar k = 0; k < NCARD; k++) begin : g_card
            if (k == 0) begin : g_send
                // Sending card only receives in loopback.
                assign ld[k]         = diag_mode && stc[1];
                assign ld_clr_cmd[k] = 1'b0;
                assign ld_word[k]    = obuf[1];
            end else begin : g_recv
                // Receiving card takes link words, or the partner in loopback.
                assign ld[k]         = diag_mode ? stc[0] : asm_valid;
                assign ld_clr_cmd[k] = !diag_mode;
                assign ld_word[k]    = diag_mode ? obuf[0] : asm_word;
            end

            xlink_card #(.W(W)) u_card (
                .clk        (clk),
                .rst_n      (rst_n),
                .op         (xl_op_e'(host_op[k])),
                .hc         (host_hc[k]),
                .wdata      (host_wdata[k]),
                .rdata      (host_rdata[k]),
                .skip       (host_skip[k]),
                .in_load    (ld[k]),
                .in_clr_cmd (ld_clr_cmd[k]),
                .in_word    (ld_word[k]),
                .stc_o      (stc[k]),
                .obuf_o     (obuf[k]),
                .flag_o     (flag[k]),
                .srq_o      (srq[k]),
                .irq_o      (irq[k]),
                .ctl_o      (ctl[k]),
                .cmd_o      (cmd[k])
            );
        end
    endgenerate

    xlink_tx_ser #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (stc[0] && !diag_mode),
        .word     (obuf[0]),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_byte  (tx_byte)
    );

    xlink_rx_asm #(.W(W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (!diag_mode),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_byte    (rx_byte),
        .word_valid (asm_valid),
        .word       (asm_word)
    );

    AST_DIAG_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        diag_mode |-> !rx_ready); // R11
endmodule

// File: tb/xlink_top_test.sv
module xlink_top_test;
    localparam int W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             diag_mode = 1'b0;
    logic [1:0][3:0]  host_op = '0;
    logic [1:0]       host_hc = '0;
    logic [1:0][W-1:0] host_wdata = '0;
    logic [1:0][W-1:0] host_rdata;
    logic [1:0]       host_skip, flag, srq, irq, ctl, cmd;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [7:0]       tx_byte;
    logic             rx_valid = 1'b0;
    logic             rx_ready;
    logic [7:0]       rx_byte = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlink_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode),
        .host_op(host_op), .host_hc(host_hc), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_skip(host_skip), .flag(flag),
        .srq(srq), .irq(irq), .ctl(ctl), .cmd(cmd),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        host_op = '0;
        host_hc = '0;
        host_wdata = '0;
    endtask

    task automatic issue(int k, logic [3:0] op, logic hc, logic [15:0] wd);
        idle();
        host_op[k] = op;
        host_hc[k] = hc;
        host_wdata[k] = wd;
    endtask

    task automatic run_op(int k, logic [3:0] op, logic hc, logic [15:0] wd);
        issue(k, op, hc, wd);
        step();
        idle();
    endtask

    task automatic send_rx(logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte = b;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flag", flag, 2'b11);
        chk("R1 srq", srq, 2'b11);
        chk("R1 ctl", ctl, 2'b00);
        chk("R1 cmd", cmd, 2'b00);
        chk("R1 irq", irq, 2'b00);
        chk("R1 tx_valid", tx_valid, 0);
        issue(0, 4'd2, 0, 0);
        #1 chk("R1 ibuf0", host_rdata[0], 0);
        issue(1, 4'd2, 0, 0);
        #1 chk("R1 ibuf1", host_rdata[1], 0);
        idle();
    endtask

    task automatic t_out_only();
        run_op(0, 4'd1, 0, 16'hA55A);
        step();
        chk("R2 no tx", tx_valid, 0);
        chk("R2 flag", flag[0], 1);
    endtask

    task automatic t_send();
        tx_ready = 1'b0;
        run_op(0, 4'd4, 0, 0);
        chk("R3 ctl set", ctl[0], 1);
        chk("R3 cmd set", cmd[0], 1);
        chk("R12 irq", irq[0], 1);
        chk("R5 tx valid", tx_valid, 1);
        chk("R5 high first", tx_byte, 8'hA5);
        step(); step();
        chk("R5 stall hold", tx_byte, 8'hA5);
        run_op(0, 4'd1, 0, 16'h1234);
        run_op(0, 4'd4, 0, 0);
        chk("R6 ctl still set", ctl[0], 1);
        chk("R6 byte unchanged", tx_byte, 8'hA5);
        tx_ready = 1'b1;
        step();
        chk("R5 low second", tx_byte, 8'h5A);
        chk("R5 low valid", tx_valid, 1);
        step();
        tx_ready = 1'b0;
        chk("R6 idle after word", tx_valid, 0);
        step(); step();
        chk("R6 no new word", tx_valid, 0);
        run_op(0, 4'd5, 0, 0);
        chk("R3 ctl clear", ctl[0], 0);
        chk("R3 cmd clear", cmd[0], 0);
        chk("R12 irq clear", irq[0], 0);
    endtask

    task automatic t_crs_skip_flag();
        run_op(1, 4'd4, 0, 0);
        run_op(1, 4'd0, 1, 0);
        chk("R10 hc clears", flag[1], 0);
        chk("R12 srq low", srq[1], 0);
        chk("R12 irq low", irq[1], 0);
        issue(1, 4'd7, 0, 0);
        #1 chk("R9 skip clear", host_skip[1], 1);
        issue(1, 4'd8, 0, 0);
        #1 chk("R9 no skip set", host_skip[1], 0);
        idle();
        run_op(1, 4'd9, 0, 0);
        chk("R4 ctl", ctl[1], 0);
        chk("R4 cmd", cmd[1], 0);
        chk("R4 flag kept 0", flag[1], 0);
        run_op(1, 4'd6, 0, 0);
        chk("R10 setf", flag[1], 1);
        issue(1, 4'd8, 0, 0);
        #1 chk("R9 skip set", host_skip[1], 1);
        idle();
        run_op(1, 4'd9, 0, 0);
        chk("R4 flag kept 1", flag[1], 1);
        run_op(1, 4'd6, 1, 0);
        chk("R10 setf with hc", flag[1], 0);
    endtask

    task automatic t_receive();
        run_op(1, 4'd4, 0, 0);
        send_rx(8'hBE);
        chk("R7 first byte no flag", flag[1], 0);
        chk("R7 first byte cmd", cmd[1], 1);
        step();
        send_rx(8'hEF);
        chk("R7 flag set", flag[1], 1);
        chk("R7 cmd clear", cmd[1], 0);
        chk("R12 srq", srq[1], 1);
        issue(1, 4'd2, 0, 16'hFFFF);
        #1 chk("R8 load", host_rdata[1], 16'hBEEF);
        issue(1, 4'd3, 0, 16'h0010);
        #1 chk("R8 merge", host_rdata[1], 16'hBEFF);
        idle();
        run_op(1, 4'd0, 1, 0);
        send_rx(8'h01);
        issue(1, 4'd0, 1, 0);
        rx_valid = 1'b1;
        rx_byte = 8'h02;
        step();
        rx_valid = 1'b0;
        idle();
        chk("R10 arrival beats hc", flag[1], 1);
    endtask

    task automatic t_diag();
        diag_mode = 1'b1;
        #1 chk("R11 rx_ready low", rx_ready, 0);
        run_op(1, 4'd0, 1, 0);
        run_op(0, 4'd1, 0, 16'h0F0F);
        run_op(0, 4'd4, 0, 0);
        chk("R11 partner flag", flag[1], 1);
        chk("R11 no tx", tx_valid, 0);
        issue(1, 4'd2, 0, 0);
        #1 chk("R11 partner ibuf", host_rdata[1], 16'h0F0F);
        idle();
        run_op(0, 4'd0, 1, 0);
        run_op(1, 4'd1, 0, 16'h3C3C);
        run_op(1, 4'd4, 0, 0);
        chk("R11 reverse flag", flag[0], 1);
        issue(0, 4'd2, 0, 0);
        #1 chk("R11 reverse ibuf", host_rdata[0], 16'h3C3C);
        idle();
        send_rx(8'h77);
        diag_mode = 1'b0;
        send_rx(8'h12);
        send_rx(8'h34);
        issue(1, 4'd2, 0, 0);
        #1 chk("R11 ignored byte", host_rdata[1], 16'h1234);
        idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_out_only();
        t_send();
        t_crs_skip_flag();
        t_receive();
        t_diag();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule